// File: doc/BRIEF.md
# Four-function selectable nibble unit

This unit takes one 4-bit word and a 2-bit function code and returns a 4-bit result with no clock or state. Four function slices look at the word at the same time. One slice adds the word's upper pair of bits to its lower pair through a chain of 1-bit adder cells with ripple carry. One slice reports whether the word is odd. One slice divides the word by four. One slice negates the word in two's complement. A 4:1 selector passes one slice's result to the output.

It is meant as a small decode or arithmetic helper inside a larger control path. The result follows the inputs after the combinational delay. Nothing is latched and no overflow is reported.

Top module: `nibble_func_unit`

## Requirements
- R1: With function code 2'b00 the result is the 3-bit sum of bits [3:2] and bits [1:0] of the input, zero-extended so that result bit 3 is always 0 (for example 4'b1110 gives 5 and 4'b1111 gives 6).
- R2: With function code 2'b01 the result is 4'b0001 when input bit 0 is 1 (odd) and 4'b0000 when it is 0 (even), so 4'b0101 gives 1.
- R3: With function code 2'b10 the result is the input shifted right by two with zeros filled in, which is the truncated quotient of division by four; result bits [3:2] are always 0.
- R4: With function code 2'b11 the result is the two's complement of the input modulo 16, so the input plus the result is 0 modulo 16, an input of 0 gives 0 and an input of 8 gives 8.
- R5: The result depends only on the present input and function code. Applying the same pair again gives the same result, whatever was applied in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 4 | Operand word |
| sel_i | input | 2 | Function code: 0 halves sum, 1 odd flag, 2 quarter, 3 negate |
| result_o | output | 4 | Result of the selected function |

## Verification
At every change of the inputs, the assertions check the properties that each function code must always have. With code 0, bit 3 of the result is zero. With code 1, the flag matches input bit 0 and the upper bits are zero. With code 2, the top two bits are zero. With code 3, the result added to the input gives zero. Exact arithmetic values need the bench's scenarios. These include the carry into bit 2 of the halves sum, the quotient for each input, the fixed points 0 and 8 of negation, and the fact that the result depends on nothing applied earlier. The bench also sweeps all 64 input and code pairs.

// File: rtl/nibble_pkg.sv
package nibble_pkg;
    localparam int unsigned WORD_W = 4;
    localparam int unsigned CODE_W = 2;
    localparam int unsigned NUM_FN = 1 << CODE_W;

    typedef enum logic [CODE_W-1:0] {
        FN_HALF_SUM = 2'd0,
        FN_ODD      = 2'd1,
        FN_QUARTER  = 2'd2,
        FN_NEGATE   = 2'd3
    } fn_code_e;
endpackage

// File: rtl/nibble_add_cell.sv
module nibble_add_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic p_d;
    always_comb begin
        p_d = a_i ^ b_i;
        s_o = p_d ^ c_i;
        c_o = (a_i & b_i) | (p_d & c_i);
    end
endmodule

// File: rtl/nibble_half_sum.sv
module nibble_half_sum #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] word_i,
    output logic [W-1:0] sum_o
);
    localparam int unsigned HW = W / 2;

    logic [HW:0]   carry_d;
    logic [HW-1:0] bits_d;

    assign carry_d[0] = 1'b0;

    for (genvar k = 0; k < HW; k++) begin : g_cell
        nibble_add_cell i_cell (
            .a_i (word_i[HW+k]),
            .b_i (word_i[k]),
            .c_i (carry_d[k]),
            .s_o (bits_d[k]),
            .c_o (carry_d[k+1])
        );
    end

    always_comb begin
        sum_o = '0;
        sum_o[HW:0] = {carry_d[HW], bits_d};
    end
endmodule

// File: rtl/nibble_unary_fns.sv
module nibble_unary_fns #(
    parameter int unsigned W     = 4,
    parameter int unsigned SHIFT = 2
) (
    input  logic [W-1:0] word_i,
    output logic [W-1:0] odd_o,
    output logic [W-1:0] quarter_o,
    output logic [W-1:0] negate_o
);
    always_comb begin
        odd_o     = '0;
        odd_o[0]  = word_i[0];
        quarter_o = '0;
        quarter_o[W-SHIFT-1:0] = word_i[W-1:SHIFT];
        negate_o  = (~word_i) + {{(W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/nibble_mux.sv
module nibble_mux #(
    parameter int unsigned W  = 4,
    parameter int unsigned SW = 2
) (
    input  logic [(1<<SW)-1:0][W-1:0] cand_i,
    input  logic [SW-1:0]             sel_i,
    output logic [W-1:0]              pick_o
);
    always_comb begin
        pick_o = cand_i[sel_i];
    end
endmodule

// File: rtl/nibble_func_unit.sv
module nibble_func_unit
    import nibble_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    input  logic [CODE_W-1:0] sel_i,
    output logic [WORD_W-1:0] result_o
);
    logic [NUM_FN-1:0][WORD_W-1:0] cand_d;

    nibble_half_sum #(.W(WORD_W)) i_half_sum (
        .word_i (data_i),
        .sum_o  (cand_d[FN_HALF_SUM])
    );

    nibble_unary_fns #(.W(WORD_W), .SHIFT(2)) i_unary (
        .word_i    (data_i),
        .odd_o     (cand_d[FN_ODD]),
        .quarter_o (cand_d[FN_QUARTER]),
        .negate_o  (cand_d[FN_NEGATE])
    );

    nibble_mux #(.W(WORD_W), .SW(CODE_W)) i_mux (
        .cand_i (cand_d),
        .sel_i  (sel_i),
        .pick_o (result_o)
    );
endmodule

// File: rtl/nibble_func_checker.sv
module nibble_func_checker
    import nibble_pkg::*;
(
    input logic [WORD_W-1:0] data_i,
    input logic [CODE_W-1:0] sel_i,
    input logic [WORD_W-1:0] result_o
);
    logic [WORD_W-1:0] wrap_d;
    always_comb wrap_d = data_i + result_o;

    always_comb begin
        if (!$isunknown({data_i, sel_i})) begin
            // R1
            half_sum_top_chk: assert (sel_i != FN_HALF_SUM || result_o[3] == 1'b0)
                else $error("half sum bit 3 set");
            // R2
            odd_flag_chk: assert (sel_i != FN_ODD || result_o == {3'b000, data_i[0]})
                else $error("odd flag wrong");
            // R3
            quarter_top_chk: assert (sel_i != FN_QUARTER || result_o[3:2] == 2'b00)
                else $error("quarter top bits set");
            // R4
            negate_sum_chk: assert (sel_i != FN_NEGATE || wrap_d == '0)
                else $error("negate does not cancel input");
        end
    end
endmodule

bind nibble_func_unit nibble_func_checker i_chk (
    .data_i   (data_i),
    .sel_i    (sel_i),
    .result_o (result_o)
);

// File: tb/test_nibble_func_unit.sv
module test_nibble_func_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] data_i = '0;
    logic [1:0] sel_i = '0;
    logic [3:0] result_o;
    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    nibble_func_unit i_nibble_func_unit (
        .data_i   (data_i),
        .sel_i    (sel_i),
        .result_o (result_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] model(input logic [3:0] d, input logic [1:0] s);
        case (s)
            2'd0:    return {1'b0, {1'b0, d[3:2]} + {1'b0, d[1:0]}};
            2'd1:    return (d % 2 == 1) ? 4'd1 : 4'd0;
            2'd2:    return d / 4;
            default: return 4'((16 - int'(d)) % 16);
        endcase
    endfunction

    task automatic apply_check(input logic [3:0] d, input logic [1:0] s,
                               input logic [3:0] exp, input string req);
        data_i = d;
        sel_i  = s;
        @(negedge clk);
        n_run++;
        if (result_o !== exp) begin
            n_fail++;
            $display("FAIL %s: in=%0d sel=%0d got %0d expected %0d", req, d, s, result_o, exp);
        end
    endtask

    task automatic t_idle;
        apply_check(4'd0, 2'd0, 4'd0, "R1 idle");
    endtask

    task automatic t_examples;
        apply_check(4'b1110, 2'd0, 4'd5, "R1");
        apply_check(4'b1111, 2'd0, 4'd6, "R1");
        apply_check(4'b0101, 2'd1, 4'd1, "R2");
        apply_check(4'b1010, 2'd1, 4'd0, "R2");
    endtask

    task automatic t_quarter;
        apply_check(4'd15, 2'd2, 4'd3, "R3");
        apply_check(4'd3,  2'd2, 4'd0, "R3");
        apply_check(4'd8,  2'd2, 4'd2, "R3");
    endtask

    task automatic t_negate;
        apply_check(4'd0, 2'd3, 4'd0,  "R4");
        apply_check(4'd8, 2'd3, 4'd8,  "R4");
        apply_check(4'd1, 2'd3, 4'd15, "R4");
        apply_check(4'd7, 2'd3, 4'd9,  "R4");
    endtask

    task automatic t_no_memory;
        apply_check(4'd6, 2'd0, 4'd3, "R5 first");
        apply_check(4'd15, 2'd3, 4'd1, "R5 between");
        apply_check(4'd9, 2'd1, 4'd1, "R5 between");
        apply_check(4'd6, 2'd0, 4'd3, "R5 repeat");
    endtask

    task automatic t_sweep;
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 16; d++) begin
                apply_check(4'(d), 2'(s), model(4'(d), 2'(s)),
                            s == 0 ? "R1" : s == 1 ? "R2" : s == 2 ? "R3" : "R4");
            end
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_idle();
        t_examples();
        t_quarter();
        t_negate();
        t_no_memory();
        t_sweep();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule